// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block drives a three-wire serial EEPROM that holds 64 words of 16 bits. On the device side it owns chip select, serial clock and serial data toward the device, and it samples the device's serial data output. On the host side it takes one request at a time through a valid/acknowledge handshake. A request names either a read or a write, a 6-bit word address and, for a write, a 16-bit data word. A read returns the stored word. A write returns a completion status that is either done or timed out.

The block generates every bit of every frame. A read is one command frame followed by sixteen received bits, and it ends with a standby toggle. A write is wrapped between a write-enable frame and a write-disable frame. After the write frame the block polls the device's data output until the device reports it is ready, and it then issues a cleanup clock pulse with the chip deselected. Every pin phase lasts `DIV` system clocks. The completion poll gives up after `POLL_MAX` samples.

The controller is a single state machine built from these states:
- `ST_IDLE`: waiting for a request. `ST_REPLY` presents the response for one cycle.
- Setup: `ST_PREP_LOW` clears the clock and data, then `ST_PREP_SEL` selects the device.
- Sending a bit: `ST_TX_SET` places the data bit, `ST_TX_HIGH` raises the clock and `ST_TX_LOW` lowers it. `ST_TX_REST` follows each field.
- Receiving a bit: `ST_RX_HIGH` raises the clock and samples, then `ST_RX_LOW` lowers it.
- Standby: `ST_SB_DROP`, `ST_SB_RISE`, `ST_SB_SEL`, `ST_SB_FALL`.
- Completion poll: `ST_POLL`.
- Cleanup: `ST_CL_DROP`, `ST_CL_RISE`, `ST_CL_FALL`.

A phase register chooses the successor state at the end of a frame or a standby toggle. The phases step through read command, read end, enable, write, poll and disable.

Top module: `uwire_eeprom_master`

## Requirements
- R1: After reset, and whenever the block is idle, the serial clock and data-in are low and busy is low. Reset also drives chip select low.
- R2: For every transmitted bit, data-in is placed before the clock rises and holds its value across the rising and the falling clock edge. After the last bit of each field, data-in is driven 0 for one phase.
- R3: A read sends opcode 3'b110 and then the 6-bit address, both most significant bit first. It then clocks in 16 bits, most significant first, sampling the device output while the clock is high and holding data-in at 0. The assembled word appears on `rsp_rdata`.
- R4: A command starts with the clock and data-in low before chip select rises. Chip select never rises while data-in is high.
- R5: Standby is four phases in this order: chip select and clock fall together, the clock rises, chip select rises, the clock falls. A read contains one standby. A write contains three.
- R6: A write sends, in this order: the enable frame (5'b10011 and then four 0 bits), a standby, opcode 3'b101 with the address and the 16 data bits, a standby, the completion poll, a standby, and the disable frame (5'b10000 and then four 0 bits). The addressed word then holds the new data and writes are disabled again.
- R7: During the poll the block samples the device output once per phase. A high sample ends the poll with `rsp_timeout`=0. If `POLL_MAX` samples all read low, the write completes with `rsp_timeout`=1.
- R8: A write ends with a cleanup: chip select and data-in drop, then one clock pulse is given with chip select low, and chip select stays low in idle. A read ends after its standby with chip select left high and with no cleanup pulse.
- R9: `req_ack` is high only in a cycle where `req_valid` is high and the block is idle. Busy is high from the next cycle until the cycle after the single-cycle `rsp_valid` pulse. Requests made while busy are ignored and have no effect on the device.
- R10: Every clock-high phase of a transmitted or received bit lasts exactly `DIV` system clocks. The clock-high part of a standby lasts two phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ack | output | 1 | Request accepted this cycle |
| busy | output | 1 | Operation in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Word read (0 after a write) |
| rsp_timeout | output | 1 | Write completion was not seen |
| ee_cs | output | 1 | Device chip select |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data toward the device |
| ee_do | input | 1 | Serial data from the device |

## Verification
A wrong state or a wrong phase shows up at the pins within a single phase. Either the clock pulses an extra time, or a standby toggle lands in the wrong place, or a frame goes out with the wrong opcode. The behavioural device in the bench then decodes garbage, and the very next read-back returns the wrong word. A shift or counter error shows up as a frame of the wrong length. That corrupts the address or the data of that same operation, and the exhaustive read sweep and the write read-backs catch it. A poll counter that is off shows up as a timeout status in the wrong state for a device that answers late. Corrupted cycle bookkeeping shows up in the widths of the clock pulses and in the standby and cleanup pulse counts for each operation.

// File: rtl/uwm_pkg.sv
package uwm_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_PREP_LOW,
        ST_PREP_SEL,
        ST_TX_SET,
        ST_TX_HIGH,
        ST_TX_LOW,
        ST_TX_REST,
        ST_RX_HIGH,
        ST_RX_LOW,
        ST_SB_DROP,
        ST_SB_RISE,
        ST_SB_SEL,
        ST_SB_FALL,
        ST_POLL,
        ST_CL_DROP,
        ST_CL_RISE,
        ST_CL_FALL,
        ST_REPLY
    } uwm_state_e;

    typedef enum logic [2:0] {
        PH_RD_CMD,
        PH_RD_END,
        PH_WEN,
        PH_WR,
        PH_POLL,
        PH_WDS
    } uwm_phase_e;

    typedef enum logic [1:0] {
        FR_READ,
        FR_WEN,
        FR_WRITE,
        FR_WDS
    } uwm_frame_e;

    localparam logic [2:0] OPC_READ  = 3'b110;
    localparam logic [2:0] OPC_WRITE = 3'b101;
    localparam logic [4:0] OPC_WEN   = 5'b10011;
    localparam logic [4:0] OPC_WDS   = 5'b10000;

endpackage

// File: rtl/uwm_interval.sv
module uwm_interval #(
    parameter int DIV = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/uwm_tx_shift.sv
module uwm_tx_shift #(
    parameter int W  = 25,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  load_bits,
    input  logic [W-1:0]  load_mask,
    input  logic [CW-1:0] load_len,
    input  logic          step,
    output logic          bit_o,
    output logic          field_end,
    output logic          empty
);
    logic [W-1:0]  sr;
    logic [W-1:0]  mk;
    logic [CW-1:0] rem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr  <= '0;
            mk  <= '0;
            rem <= '0;
        end else if (load) begin
            sr  <= load_bits;
            mk  <= load_mask;
            rem <= load_len;
        end else if (step) begin
            sr  <= {sr[W-2:0], 1'b0};
            mk  <= {mk[W-2:0], 1'b0};
            rem <= rem - 1'b1;
        end
    end

    assign bit_o     = sr[W-1];
    assign field_end = mk[W-1];
    assign empty     = (rem == '0);
endmodule

// File: rtl/uwm_rx_shift.sv
module uwm_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         take,
    input  logic         din,
    output logic [W-1:0] word,
    output logic         full
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            cnt  <= '0;
        end else if (clear) begin
            word <= '0;
            cnt  <= '0;
        end else if (take) begin
            word <= {word[W-2:0], din};
            cnt  <= cnt + 1'b1;
        end
    end

    assign full = (cnt == CW'(W));
endmodule

// File: rtl/uwire_eeprom_master.sv
module uwire_eeprom_master
    import uwm_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int DIV      = 2500,
    parameter int POLL_MAX = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic              busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_timeout,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int FRAME_W = 3 + ADDR_W + DATA_W;
    localparam int LEN_W   = $clog2(FRAME_W + 1);
    localparam int CMD_LEN = 3 + ADDR_W;
    localparam int PC_W    = $clog2(POLL_MAX + 1);
    localparam int DUMMY_W = ADDR_W - 2;
    localparam int POS_OP3 = FRAME_W - 3;
    localparam int POS_OP5 = FRAME_W - 5;
    localparam int POS_ADR = FRAME_W - CMD_LEN;

    uwm_state_e state, state_n;
    uwm_phase_e phase, phase_n;
    uwm_frame_e ld_kind;

    logic              tick, run;
    logic              ld, tx_step, rx_take, rx_clear;
    logic              pcnt_clr, pcnt_inc, tmo_set, tmo_clr, accept;
    logic              tx_bit, tx_fend, tx_empty, rx_full;
    logic [PC_W-1:0]   pcnt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [FRAME_W-1:0] ld_bits, ld_mask;
    logic [LEN_W-1:0]   ld_len;

    assign run     = (state != ST_IDLE) && (state != ST_REPLY);
    assign busy    = (state != ST_IDLE);
    assign req_ack = req_valid && (state == ST_IDLE);
    assign rsp_valid = (state == ST_REPLY);

    uwm_interval #(.DIV(DIV)) u_interval (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    uwm_tx_shift #(.W(FRAME_W), .CW(LEN_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_bits(ld_bits),
        .load_mask(ld_mask), .load_len(ld_len), .step(tx_step),
        .bit_o(tx_bit), .field_end(tx_fend), .empty(tx_empty)
    );

    uwm_rx_shift #(.W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clear(rx_clear), .take(rx_take),
        .din(ee_do), .word(rsp_rdata), .full(rx_full)
    );

    // Frame images, left aligned; the mask flags the last bit of each field.
    always_comb begin
        ld_bits = '0;
        ld_mask = '0;
        ld_len  = LEN_W'(CMD_LEN);
        ld_mask[POS_ADR] = 1'b1;
        unique case (ld_kind)
            FR_READ: begin
                ld_bits = {OPC_READ, addr_q, {DATA_W{1'b0}}};
                ld_mask[POS_OP3] = 1'b1;
            end
            FR_WRITE: begin
                ld_bits = {OPC_WRITE, addr_q, wdata_q};
                ld_mask[POS_OP3] = 1'b1;
                ld_mask[0] = 1'b1;
                ld_len = LEN_W'(FRAME_W);
            end
            FR_WEN: begin
                ld_bits = {OPC_WEN, {DUMMY_W{1'b0}}, {DATA_W{1'b0}}};
                ld_mask[POS_OP5] = 1'b1;
            end
            FR_WDS: begin
                ld_bits = {OPC_WDS, {DUMMY_W{1'b0}}, {DATA_W{1'b0}}};
                ld_mask[POS_OP5] = 1'b1;
            end
            default: ;
        endcase
    end

    // Next-state logic.
    always_comb begin
        state_n  = state;
        phase_n  = phase;
        ld       = 1'b0;
        ld_kind  = FR_READ;
        tx_step  = 1'b0;
        rx_take  = 1'b0;
        rx_clear = 1'b0;
        pcnt_clr = 1'b0;
        pcnt_inc = 1'b0;
        tmo_set  = 1'b0;
        tmo_clr  = 1'b0;
        accept   = 1'b0;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                accept   = 1'b1;
                rx_clear = 1'b1;
                tmo_clr  = 1'b1;
                phase_n  = req_write ? PH_WEN : PH_RD_CMD;
                state_n  = ST_PREP_LOW;
            end
            ST_PREP_LOW: if (tick) state_n = ST_PREP_SEL;
            ST_PREP_SEL: if (tick) begin
                ld      = 1'b1;
                ld_kind = (phase == PH_WEN) ? FR_WEN : FR_READ;
                state_n = ST_TX_SET;
            end
            ST_TX_SET:  if (tick) state_n = ST_TX_HIGH;
            ST_TX_HIGH: if (tick) state_n = ST_TX_LOW;
            ST_TX_LOW: if (tick) begin
                tx_step = 1'b1;
                state_n = tx_fend ? ST_TX_REST : ST_TX_SET;
            end
            ST_TX_REST: if (tick) begin
                if (!tx_empty)
                    state_n = ST_TX_SET;
                else if (phase == PH_RD_CMD)
                    state_n = ST_RX_HIGH;
                else if (phase == PH_WDS)
                    state_n = ST_CL_DROP;
                else
                    state_n = ST_SB_DROP;
            end
            ST_RX_HIGH: if (tick) begin
                rx_take = 1'b1;
                state_n = ST_RX_LOW;
            end
            ST_RX_LOW: if (tick) begin
                if (rx_full) begin
                    phase_n = PH_RD_END;
                    state_n = ST_SB_DROP;
                end else begin
                    state_n = ST_RX_HIGH;
                end
            end
            ST_SB_DROP: if (tick) state_n = ST_SB_RISE;
            ST_SB_RISE: if (tick) state_n = ST_SB_SEL;
            ST_SB_SEL:  if (tick) state_n = ST_SB_FALL;
            ST_SB_FALL: if (tick) begin
                unique case (phase)
                    PH_WEN: begin
                        ld      = 1'b1;
                        ld_kind = FR_WRITE;
                        phase_n = PH_WR;
                        state_n = ST_TX_SET;
                    end
                    PH_WR: begin
                        pcnt_clr = 1'b1;
                        phase_n  = PH_POLL;
                        state_n  = ST_POLL;
                    end
                    PH_POLL: begin
                        ld      = 1'b1;
                        ld_kind = FR_WDS;
                        phase_n = PH_WDS;
                        state_n = ST_TX_SET;
                    end
                    default: state_n = ST_REPLY;
                endcase
            end
            ST_POLL: if (tick) begin
                if (ee_do) begin
                    state_n = ST_SB_DROP;
                end else if (pcnt == PC_W'(POLL_MAX - 1)) begin
                    tmo_set = 1'b1;
                    state_n = ST_SB_DROP;
                end else begin
                    pcnt_inc = 1'b1;
                end
            end
            ST_CL_DROP: if (tick) state_n = ST_CL_RISE;
            ST_CL_RISE: if (tick) state_n = ST_CL_FALL;
            ST_CL_FALL: if (tick) state_n = ST_REPLY;
            ST_REPLY:   state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // State, phase and request registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            phase       <= PH_RD_CMD;
            pcnt        <= '0;
            rsp_timeout <= 1'b0;
            addr_q      <= '0;
            wdata_q     <= '0;
        end else begin
            state <= state_n;
            phase <= phase_n;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (pcnt_clr)
                pcnt <= '0;
            else if (pcnt_inc)
                pcnt <= pcnt + 1'b1;
            if (tmo_clr)
                rsp_timeout <= 1'b0;
            else if (tmo_set)
                rsp_timeout <= 1'b1;
        end
    end

    // Registered pin drive decoded from the current state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ee_cs <= 1'b0;
            ee_sk <= 1'b0;
            ee_di <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_REPLY, ST_PREP_LOW: begin
                    ee_sk <= 1'b0; ee_di <= 1'b0;
                end
                ST_PREP_SEL, ST_TX_REST, ST_RX_LOW, ST_SB_FALL, ST_POLL: begin
                    ee_cs <= 1'b1; ee_sk <= 1'b0; ee_di <= 1'b0;
                end
                ST_TX_SET, ST_TX_LOW: begin
                    ee_cs <= 1'b1; ee_sk <= 1'b0; ee_di <= tx_bit;
                end
                ST_TX_HIGH: begin
                    ee_cs <= 1'b1; ee_sk <= 1'b1; ee_di <= tx_bit;
                end
                ST_RX_HIGH, ST_SB_SEL: begin
                    ee_cs <= 1'b1; ee_sk <= 1'b1; ee_di <= 1'b0;
                end
                ST_SB_RISE, ST_CL_RISE: begin
                    ee_cs <= 1'b0; ee_sk <= 1'b1; ee_di <= 1'b0;
                end
                ST_SB_DROP, ST_CL_DROP, ST_CL_FALL: begin
                    ee_cs <= 1'b0; ee_sk <= 1'b0; ee_di <= 1'b0;
                end
                default: begin
                    ee_cs <= 1'b0; ee_sk <= 1'b0; ee_di <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/uwm_checker.sv
module uwm_checker #(
    parameter int DIV = 2500
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic req_ack,
    input logic rsp_valid,
    input logic ee_cs,
    input logic ee_sk,
    input logic ee_di
);
    logic [31:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (ee_sk)
            hi_cnt <= hi_cnt + 1;
        else
            hi_cnt <= '0;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ee_sk && !ee_di));

    p_di_hold_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sk) |-> $stable(ee_di));

    p_di_hold_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_sk) |-> $stable(ee_di));

    p_select_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> !ee_di);

    p_deselect_clk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_cs) |-> (!ee_sk && !$past(ee_sk)));

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> busy);

    p_reply_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && !busy));

    p_high_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_sk) |-> ((hi_cnt == 32'(DIV)) || (ee_cs && hi_cnt == 32'(2 * DIV))));
endmodule

bind uwire_eeprom_master uwm_checker #(.DIV(DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .req_ack(req_ack),
    .rsp_valid(rsp_valid), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/sim_uwire_eeprom_master.sv
module sim_uwire_eeprom_master;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 3;
    localparam int POLL_MAX   = 10;
    localparam int M_CMD = 0, M_RDOUT = 1, M_IGN = 2, M_STAT = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic req_ack, busy, rsp_valid, rsp_timeout, ee_cs, ee_sk, ee_di;
    logic [15:0] rsp_rdata;
    logic ee_do = 1'b0;

    int total = 0, bad = 0, cyc = 0;

    uwire_eeprom_master #(.ADDR_W(6), .DATA_W(16), .DIV(DIV), .POLL_MAX(POLL_MAX)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural device model, evaluated away from the active edge.
    logic [15:0] mem [64];
    logic [24:0] m_cmd;
    logic [15:0] m_out;
    int m_nbits, m_mode, m_left, m_delay;
    logic m_en, m_skip, m_armed, m_pending, m_never;
    logic [5:0]  m_paddr;
    logic [15:0] m_pdata;
    logic p_cs = 1'b0, p_sk = 1'b0, p_di = 1'b0, cs_at_rise = 1'b0;
    int rise_cyc = 0;
    int sb_cnt = 0, low_cnt = 0, err_setup = 0, err_di = 0, err_rxdi = 0, err_w = 0, err_sb = 0;

    initial begin
        m_cmd = '0; m_out = '0; m_nbits = 0; m_mode = M_IGN; m_left = 0; m_delay = 20;
        m_en = 0; m_skip = 0; m_armed = 0; m_pending = 0; m_never = 0;
        m_paddr = '0; m_pdata = '0;
        for (int i = 0; i < 64; i++) mem[i] = 16'((i * 40503 + 4660) ^ 16'hA5C3);
    end

    always @(negedge clk) begin
        if (m_left > 0) m_left = m_left - 1;
        if (ee_cs && !p_cs) begin
            if (ee_di) err_setup++;
            if (ee_sk && !p_sk) err_setup++;
            if (ee_sk && p_sk) sb_cnt++;
            m_nbits = 0;
            if (m_pending) begin
                if (m_mode == M_STAT && m_left == 0) begin
                    m_pending = 0; m_mode = M_CMD;
                end else m_mode = M_STAT;
            end else m_mode = M_CMD;
        end
        if (!ee_cs && p_cs) begin
            if (ee_sk || p_sk) err_sb++;
            if (m_armed) begin
                m_armed = 0; m_pending = 1;
                m_left = m_never ? 1000000 : m_delay;
                mem[m_paddr] = m_pdata;
            end
        end
        if (ee_sk && !p_sk) begin
            if (ee_di != p_di) err_di++;
            rise_cyc = cyc; cs_at_rise = ee_cs;
            if (!ee_cs) low_cnt++;
            else if (m_mode == M_RDOUT) begin
                if (ee_di) err_rxdi++;
            end else if (m_mode == M_CMD) begin
                m_cmd = {m_cmd[23:0], ee_di};
                m_nbits++;
                if (m_nbits == 9) begin
                    if (m_cmd[8:6] == 3'b110) begin
                        m_out = mem[m_cmd[5:0]]; m_mode = M_RDOUT; m_skip = 1;
                    end else if (m_cmd[8:6] == 3'b100) begin
                        if (m_cmd[5:4] == 2'b11) m_en = 1;
                        else if (m_cmd[5:4] == 2'b00) m_en = 0;
                        m_mode = M_IGN;
                    end else if (m_cmd[8:6] != 3'b101) m_mode = M_IGN;
                end else if (m_nbits == 25) begin
                    if (m_en) begin
                        m_armed = 1; m_paddr = m_cmd[21:16]; m_pdata = m_cmd[15:0];
                    end
                    m_mode = M_IGN;
                end
            end
        end
        if (!ee_sk && p_sk) begin
            if (ee_di != p_di) err_di++;
            if (cs_at_rise && (cyc - rise_cyc) != DIV) err_w++;
            if (!cs_at_rise && ee_cs && (cyc - rise_cyc) != 2 * DIV) err_w++;
            if (m_mode == M_RDOUT) begin
                if (m_skip) m_skip = 0;
                else m_out = {m_out[14:0], 1'b0};
            end
        end
        if (m_mode == M_STAT && ee_cs) ee_do = (m_left == 0);
        else if (m_mode == M_RDOUT) ee_do = m_out[15];
        else ee_do = 1'b0;
        p_cs = ee_cs; p_sk = ee_sk; p_di = ee_di;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic wr, input logic [5:0] a, input logic [15:0] d,
                          output logic [15:0] rd, output logic tmo, output logic acked);
        int n;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        #1 acked = req_ack;
        @(negedge clk);
        req_valid = 0;
        n = 0;
        while (!rsp_valid && n < 20000) begin @(negedge clk); n++; end
        rd = rsp_rdata; tmo = rsp_timeout;
        if (n >= 20000) chk("R9 response missing", 0, 1);
    endtask

    initial begin
        wait (cyc == 190000);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] rd, exp;
        logic tmo, acked;
        int acks;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset cs", ee_cs, 0);
        chk("R1 reset sk", ee_sk, 0);
        chk("R1 reset di", ee_di, 0);
        chk("R1 reset busy", busy, 0);

        // R3 / R5 / R8: exhaustive read sweep.
        for (int a = 0; a < 64; a++) begin
            sb_cnt = 0; low_cnt = 0;
            run_op(0, 6'(a), 16'h0, rd, tmo, acked);
            chk("R9 ack on read", acked, 1);
            chk("R3 read data", rd, mem[a]);
            chk("R5 one standby per read", sb_cnt, 1);
            @(negedge clk);
            chk("R8 read leaves cs high", ee_cs, 1);
            chk("R8 no cleanup pulse on read", low_cnt, 1);
        end
        chk("R3 di low while receiving", err_rxdi, 0);

        // R6 / R7 / R8: writes with differing completion delays.
        for (int k = 0; k < 4; k++) begin
            logic [5:0] wa;
            logic [15:0] wd;
            wa = (k == 0) ? 6'd0 : (k == 1) ? 6'd63 : (k == 2) ? 6'd21 : 6'd42;
            wd = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : (k == 2) ? 16'h8001 : 16'h7E5A;
            m_delay = 5 + k * 8;
            sb_cnt = 0; low_cnt = 0;
            run_op(1, wa, wd, rd, tmo, acked);
            chk("R9 ack on write", acked, 1);
            chk("R7 completion seen", tmo, 0);
            chk("R6 device word updated", mem[wa], wd);
            chk("R6 writes disabled after", m_en, 0);
            chk("R5 three standbys per write", sb_cnt, 3);
            chk("R8 cleanup pulse count", low_cnt, 4);
            chk("R8 write leaves cs low", ee_cs, 0);
            chk("R6 write response data zero", rd, 0);
            run_op(0, wa, 16'h0, rd, tmo, acked);
            chk("R6 read back via block", rd, wd);
        end

        // R9: requests while busy are ignored.
        exp = mem[7];
        acks = 0;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 6'd7;
        @(negedge clk);
        req_write = 1; req_wdata = ~exp;
        while (!rsp_valid) begin
            @(negedge clk);
            if (req_ack) acks++;
            if (cyc > 180000) break;
        end
        rd = rsp_rdata;
        req_valid = 0;
        chk("R9 no ack while busy", acks, 0);
        chk("R9 busy read data intact", rd, exp);
        chk("R9 ignored write left word", mem[7], exp);
        @(negedge clk);
        chk("R9 idle after reply", busy, 0);

        // R7: device never ready.
        m_never = 1;
        sb_cnt = 0;
        run_op(1, 6'd9, 16'h1234, rd, tmo, acked);
        chk("R7 timeout reported", tmo, 1);
        chk("R7 standbys still issued", sb_cnt, 3);
        m_never = 0; m_pending = 0; m_left = 0; m_en = 0; m_mode = M_IGN;
        run_op(1, 6'd10, 16'hBEEF, rd, tmo, acked);
        chk("R7 timeout cleared on next write", tmo, 0);
        run_op(0, 6'd10, 16'h0, rd, tmo, acked);
        chk("R7 recovery read back", rd, 16'hBEEF);

        chk("R2 di stable at clock edges", err_di, 0);
        chk("R4 select with clock and data low", err_setup, 0);
        chk("R5 deselect with clock low", err_sb, 0);
        chk("R10 clock high widths", err_w, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule